// File: doc/BRIEF.md
# Registered Bidirectional Bus Transceiver

This block links two 8-bit buses, side A and side B. Each side has a storage register, a one-cycle load strobe, a source select and an output enable. A bus can carry the other bus's live value straight through, or the value held in the opposite register. No bit is inverted on either path. Each bidirectional bus appears as three signals: an input, an output and an output enable. The surrounding logic builds the pad or the on-chip bus from these.

Both registers run on one clock and load only when their strobe is high. A register always captures the value actually present on its own bus. When its side is driving, that value is the block's own output; otherwise it is the external input. A register can therefore take in data that has come across from the other side. Several patterns follow from this:

- One transfer can fill both registers with the same value.
- Two stored values can be swapped in one cycle.

Turning on both directions while both selects are live would close a combinational loop. The block detects this case, raises a flag and serves both buses from storage instead.

Top module: `xfer_reg_bridge`

## Requirements
- R1: An asynchronous active-low reset clears both storage registers to zero.
- R2: On a clock edge with `loadA` high, register A takes the effective A value. That value is `aOut` when A is driving and `aIn` otherwise. `loadB` does the same for register B with the B values. A register whose strobe is low keeps its value, whatever its bus carries.
- R3: `bOe` follows `enAtoB` (active high). `aOe` is the inverse of `enBtoANeg` (active low). With `enAtoB` low and `enBtoANeg` high, neither bus is driven.
- R4: With `selAtoB` = 0 and B driving, `bOut` equals the live A value. With `selBtoA` = 0 and A driving, `aOut` equals the live B value.
- R5: With `selAtoB` = 1, `bOut` equals register A. With `selBtoA` = 1, `aOut` equals register B.
- R6: Loading stays enabled while a side drives its bus. A strobed register then captures the value its own side is driving.
- R7: B driving with `selAtoB` = 0 and both strobes high in one cycle loads `aIn` into both registers. The mirror case is A driving with `selBtoA` = 0, which loads `bIn` into both registers.
- R8: Both sides driving, both selects at 1 and both strobes high exchange the contents of the two registers in one cycle.
- R9: Both sides driving with both selects at 0 raises `contention`. Both outputs are then served from storage: `bOut` = register A and `aOut` = register B.
- R10: `contention` is low in every other combination of enables and selects.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous reset, active low |
| aIn | input | 8 | Value seen on bus A from outside |
| aOut | output | 8 | Value the block drives onto bus A |
| aOe | output | 1 | Block drives bus A |
| bIn | input | 8 | Value seen on bus B from outside |
| bOut | output | 8 | Value the block drives onto bus B |
| bOe | output | 1 | Block drives bus B |
| loadA | input | 1 | Load strobe for register A |
| loadB | input | 1 | Load strobe for register B |
| enAtoB | input | 1 | Drive bus B, active high |
| enBtoANeg | input | 1 | Drive bus A, active low |
| selAtoB | input | 1 | Source for bus B: 0 live A, 1 register A |
| selBtoA | input | 1 | Source for bus A: 0 live B, 1 register B |
| contention | output | 1 | Both directions enabled with both selects live |

## Verification
The bench builds the block at its default width of 8 bits. It uses bit patterns whose halves differ and whose complements differ, such as 0x0F against 0xF0 and 0xA5 against 0x3C. With these patterns, an exchanged register pair is distinguishable from a copied one, and a live path from a stored one. At this width the directed rows cover isolation, both live paths, both stored paths, the two store-into-both cases, the swap and the contention fallback. A run of pseudo-random control and data steps then mixes strobes with every enable and select setting.

// File: rtl/xrb_pkg.sv
package xrb_pkg;
  typedef struct packed {
    logic aOe;
    logic bOe;
    logic aStored;
    logic bStored;
    logic loadA;
    logic loadB;
    logic contention;
  } xrbCtl_t;
endpackage

// File: rtl/xrb_ctrl.sv
module xrb_ctrl
  import xrb_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    enAtoB,
  input  logic    enBtoANeg,
  input  logic    selAtoB,
  input  logic    selBtoA,
  input  logic    loadA,
  input  logic    loadB,
  output xrbCtl_t ctl
);
  logic driveA, driveB, loopRisk;

  always_comb begin
    driveB   = enAtoB;
    driveA   = ~enBtoANeg;
    loopRisk = driveA & driveB & ~selAtoB & ~selBtoA;
    ctl.aOe        = driveA;
    ctl.bOe        = driveB;
    ctl.contention = loopRisk;
    ctl.aStored    = selBtoA | loopRisk;
    ctl.bStored    = selAtoB | loopRisk;
    ctl.loadA      = loadA;
    ctl.loadB      = loadB;
  end

  assert_isolation_R3: assert property (@(posedge clk) disable iff (!rstN)
    (!enAtoB && enBtoANeg) |-> (!ctl.aOe && !ctl.bOe));
  assert_fallback_R9: assert property (@(posedge clk) disable iff (!rstN)
    ctl.contention |-> (ctl.aStored && ctl.bStored && ctl.aOe && ctl.bOe));
  assert_no_false_flag_R10: assert property (@(posedge clk) disable iff (!rstN)
    (selAtoB || selBtoA || enBtoANeg || !enAtoB) |-> !ctl.contention);
endmodule

// File: rtl/xrb_datapath.sv
module xrb_datapath
  import xrb_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  xrbCtl_t          ctl,
  input  logic [WIDTH-1:0] aIn,
  input  logic [WIDTH-1:0] bIn,
  output logic [WIDTH-1:0] aOut,
  output logic [WIDTH-1:0] bOut
);
  logic [WIDTH-1:0] regA, regB;
  logic [WIDTH-1:0] aEff, bEff;

  // Loop-free source selection: a live path whose far side also drives
  // always meets a stored source there (otherwise contention forced storage).
  always_comb begin
    bOut = ctl.bStored ? regA : (ctl.aOe ? regB : aIn);
    aOut = ctl.aStored ? regB : (ctl.bOe ? regA : bIn);
    aEff = ctl.aOe ? aOut : aIn;
    bEff = ctl.bOe ? bOut : bIn;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      regA <= '0;
      regB <= '0;
    end else begin
      if (ctl.loadA) regA <= aEff;
      if (ctl.loadB) regB <= bEff;
    end
  end

  assert_capture_input_R2: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.loadA && !ctl.aOe) |=> (regA == $past(aIn)));
  assert_hold_R2: assert property (@(posedge clk) disable iff (!rstN)
    !ctl.loadA |=> $stable(regA));
  assert_live_path_R4: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.bOe && !ctl.bStored && !ctl.aOe) |-> (bOut == aIn));
  assert_stored_path_R5: assert property (@(posedge clk) disable iff (!rstN)
    ctl.aStored |-> (aOut == regB));
  assert_swap_R8: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.loadA && ctl.loadB && ctl.aOe && ctl.bOe && ctl.aStored && ctl.bStored)
    |=> (regA == $past(regB) && regB == $past(regA)));
endmodule

// File: rtl/xfer_reg_bridge.sv
module xfer_reg_bridge
  import xrb_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] aIn,
  output logic [WIDTH-1:0] aOut,
  output logic             aOe,
  input  logic [WIDTH-1:0] bIn,
  output logic [WIDTH-1:0] bOut,
  output logic             bOe,
  input  logic             loadA,
  input  logic             loadB,
  input  logic             enAtoB,
  input  logic             enBtoANeg,
  input  logic             selAtoB,
  input  logic             selBtoA,
  output logic             contention
);
  xrbCtl_t ctl;

  xrb_ctrl uCtrl (
    .clk(clk), .rstN(rstN), .enAtoB(enAtoB), .enBtoANeg(enBtoANeg),
    .selAtoB(selAtoB), .selBtoA(selBtoA), .loadA(loadA), .loadB(loadB),
    .ctl(ctl)
  );

  xrb_datapath #(.WIDTH(WIDTH)) uData (
    .clk(clk), .rstN(rstN), .ctl(ctl), .aIn(aIn), .bIn(bIn),
    .aOut(aOut), .bOut(bOut)
  );

  assign aOe        = ctl.aOe;
  assign bOe        = ctl.bOe;
  assign contention = ctl.contention;
endmodule

// File: tb/xfer_reg_bridge_test.sv
module xfer_reg_bridge_test;
  localparam int W = 8;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [W-1:0] aIn = '0, bIn = '0;
  logic [W-1:0] aOut, bOut;
  logic aOe, bOe, contention;
  logic loadA = 0, loadB = 0, enAtoB = 0, enBtoANeg = 1, selAtoB = 0, selBtoA = 0;

  always #2 clk = ~clk;

  xfer_reg_bridge #(.WIDTH(W)) uut (
    .clk(clk), .rstN(rstN), .aIn(aIn), .aOut(aOut), .aOe(aOe),
    .bIn(bIn), .bOut(bOut), .bOe(bOe), .loadA(loadA), .loadB(loadB),
    .enAtoB(enAtoB), .enBtoANeg(enBtoANeg), .selAtoB(selAtoB),
    .selBtoA(selBtoA), .contention(contention)
  );

  typedef struct {
    logic [W-1:0] aV; logic [W-1:0] bV;
    logic aE; logic bE; logic c; string tag;
  } item_t;

  item_t expQ[$];
  int checks = 0, fails = 0;
  logic [W-1:0] mA = '0, mB = '0;
  bit done = 0;

  task automatic step(input logic gab, input logic gbaN, input logic sab, input logic sba,
                      input logic la, input logic lb, input logic [W-1:0] ai,
                      input logic [W-1:0] bi, input string tag);
    item_t it;
    logic drvA, drvB, cf, aSt, bSt;
    logic [W-1:0] ea, eb, effA, effB;
    @(negedge clk);
    enAtoB = gab; enBtoANeg = gbaN; selAtoB = sab; selBtoA = sba;
    loadA = la; loadB = lb; aIn = ai; bIn = bi;
    drvB = gab; drvA = !gbaN;
    cf = drvA && drvB && !sab && !sba;
    aSt = sba || cf; bSt = sab || cf;
    ea = aSt ? mB : '0;
    eb = bSt ? mA : '0;
    if (!bSt) eb = drvA ? ea : ai;
    if (!aSt) ea = drvB ? eb : bi;
    effA = drvA ? ea : ai;
    effB = drvB ? eb : bi;
    it.aV = ea; it.bV = eb; it.aE = drvA; it.bE = drvB; it.c = cf; it.tag = tag;
    expQ.push_back(it);
    if (la) mA = effA;
    if (lb) mB = effB;
  endtask

  // monitor: compares one expected item per cycle, away from the edge
  initial begin
    forever begin
      @(negedge clk); #1;
      if (expQ.size() > 0) begin
        item_t e;
        e = expQ.pop_front();
        checks++;
        if (aOe !== e.aE || bOe !== e.bE || contention !== e.c ||
            (e.aE && aOut !== e.aV) || (e.bE && bOut !== e.bV)) begin
          fails++;
          $display("FAIL %s: got aOe=%b bOe=%b c=%b aOut=%h bOut=%h exp aOe=%b bOe=%b c=%b aOut=%h bOut=%h",
                   e.tag, aOe, bOe, contention, aOut, bOut, e.aE, e.bE, e.c, e.aV, e.bV);
        end
      end
    end
  end

  initial begin
    #400000;
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: got hung run, exp completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    logic [31:0] lfsr;
    lfsr = 32'h1ACE_B00C;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    // R1: reset state seen through both stored paths
    step(1, 0, 1, 1, 0, 0, 8'h00, 8'h00, "R1");
    // R3 isolation, R2 load both from inputs
    step(0, 1, 0, 0, 1, 1, 8'hA5, 8'h3C, "R3");
    step(1, 0, 1, 1, 0, 0, 8'h00, 8'h00, "R5");
    // R2: no strobe holds despite bus changes
    step(0, 1, 0, 0, 0, 0, 8'hFF, 8'hFF, "R2");
    step(1, 0, 1, 1, 0, 0, 8'h11, 8'h22, "R2");
    // R4 live paths
    step(1, 1, 0, 0, 0, 0, 8'h5A, 8'h00, "R4");
    step(0, 0, 0, 0, 0, 0, 8'h00, 8'hC3, "R4");
    // R7 store into both, and mirror
    step(1, 1, 0, 0, 1, 1, 8'h77, 8'h00, "R7");
    step(1, 0, 1, 1, 0, 0, 8'h00, 8'h00, "R7");
    step(0, 0, 0, 0, 1, 1, 8'h00, 8'hE1, "R7");
    step(1, 0, 1, 1, 0, 0, 8'h00, 8'h00, "R7");
    // R6: A drives stored B while loading A
    step(0, 1, 0, 0, 0, 1, 8'h00, 8'h96, "R6");
    step(0, 0, 0, 1, 1, 0, 8'h12, 8'h34, "R6");
    step(1, 0, 1, 1, 0, 0, 8'h00, 8'h00, "R6");
    // R8 swap
    step(0, 1, 0, 0, 1, 1, 8'h0F, 8'hF0, "R8");
    step(1, 0, 1, 1, 1, 1, 8'h00, 8'h00, "R8");
    step(1, 0, 1, 1, 0, 0, 8'h00, 8'h00, "R8");
    // R9 contention fallback, with loads
    step(1, 0, 0, 0, 0, 0, 8'h11, 8'h22, "R9");
    step(1, 0, 0, 0, 1, 1, 8'h11, 8'h22, "R9");
    step(1, 0, 1, 1, 0, 0, 8'h00, 8'h00, "R9");
    // R10: mixed selects, no flag
    step(1, 0, 0, 1, 0, 0, 8'h3E, 8'h00, "R10");
    step(1, 0, 1, 0, 0, 0, 8'h00, 8'h4D, "R10");
    // pseudo-random mix
    for (int i = 0; i < 200; i++) begin
      lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
      lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
      step(lfsr[0], lfsr[1], lfsr[2], lfsr[3], lfsr[4], lfsr[5],
           lfsr[15:8], lfsr[23:16], "R2");
    end
    @(negedge clk); @(negedge clk);
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule